// File: doc/BRIEF.md
# Thread Join Unit

This unit is the synchronization stage of a non-blocking multithreaded processor. A thread is created by allocating an activation frame for it. The frame records the thread's code pointer and a join count, which is the number of input values the thread has to receive before it can run. Producer threads then deliver their results into the frame as slot writes. Each accepted write lowers the join count by one. The write that brings the count to zero places the thread, as its frame id and code pointer, into a ready queue. The pre-load stage takes threads from that queue. It reads the delivered values out of the frame through a combinational read port, and from then on the thread runs to completion without blocking.

Frames go back to the pool only through an explicit free command. One example is the branch thread that was not taken. A free and an allocate in the same cycle are both carried out. Writes that cannot be accepted are dropped, and a one-cycle error pulse is raised for them.

Top module: `thread_join_unit`

## Requirements
- R1: After reset every frame is free, `alloc_busy`, `rdy_valid` and `st_err` are low, and `alloc_fid` shows frame 0.
- R2: When `alloc_req` is high with a nonzero `alloc_count` and a frame is free, `alloc_grant` rises in the same cycle. `alloc_fid` names the lowest-numbered free frame, and that frame is allocated from the next cycle on.
- R3: `alloc_busy` is high exactly when all frames are allocated, and while it is high no request is granted.
- R4: A request with an `alloc_count` of zero is not granted and uses no frame.
- R5: Each accepted write to an allocated frame lowers its join count by one. The write that takes the count from 1 to 0 puts the entry {frame id, code pointer} into the ready queue, and `rdy_valid` is high in the following cycle.
- R6: The ready queue hands out entries in completion order. An entry is removed on a cycle where `rdy_pop` and `rdy_valid` are both high.
- R7: A write to an unallocated frame, or to a frame whose count is already zero, pulses `st_err` high in the following cycle. Such a write changes no count, no slot data and no queue entry.
- R8: A free of an allocated frame clears its count and returns it to the pool, so later writes to it are errors and a later allocation can pick it. A free of an unallocated frame has no effect.
- R9: An allocate and a free in the same cycle are both carried out. The grant is chosen from the frames that were free before that cycle.
- R10: When a write and a free target the same allocated frame in the same cycle, the free takes effect, and the write raises no error and makes no queue entry.
- R11: A write that would take a count to zero while the ready queue is full raises `st_err` and is ignored, so the count stays at one.
- R12: `pl_data` shows, combinationally, the last value accepted into slot `pl_slot` of frame `pl_fid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Frame allocation request |
| alloc_code | input | CODE_W | Code pointer of the new thread |
| alloc_count | input | CNT_W | Number of inputs the thread waits for |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_busy | output | 1 | No frame free |
| alloc_fid | output | FID_W | Frame id given to the request |
| st_valid | input | 1 | Write into a frame slot |
| st_fid | input | FID_W | Target frame |
| st_slot | input | SLOT_W | Target slot |
| st_data | input | DATA_W | Value written |
| st_err | output | 1 | Previous cycle's write was rejected |
| free_valid | input | 1 | Release a frame |
| free_fid | input | FID_W | Frame to release |
| rdy_valid | output | 1 | Ready queue not empty |
| rdy_fid | output | FID_W | Frame id at queue head |
| rdy_code | output | CODE_W | Code pointer at queue head |
| rdy_pop | input | 1 | Remove queue head |
| pl_fid | input | FID_W | Pre-load read frame |
| pl_slot | input | SLOT_W | Pre-load read slot |
| pl_data | output | DATA_W | Pre-load read value |

## Verification
`alloc_grant`, `alloc_fid` and `alloc_busy` respond in the same cycle as the request, so the bench samples them 1 ns after it drives the inputs, before the next rising edge. `st_err` and the ready-queue head are registered, so the bench checks them 1 ns after the edge that follows the write. `pl_data` is read after that same edge, once the slot write has been committed. A bench-side model predicts every result. It tracks frame ownership, counts, slot contents and queue order, and it is advanced only at the edge at which the design's state is due to change.

// File: rtl/tju_pkg.sv
// Shared types for the thread join unit.
package tju_pkg;
    // Outcome of the slot write presented in the current cycle
    typedef enum logic [2:0] {
        SV_NONE,  // no write
        SV_OK,    // accepted, count stays above zero
        SV_LAST,  // accepted, count reaches zero, thread becomes ready
        SV_BAD,   // rejected, error pulse
        SV_DROP   // discarded because the same frame is freed this cycle
    } st_verdict_e;
endpackage

// File: rtl/tju_free_pool.sv
// Frame ownership bitmap. It offers the lowest-numbered free frame.
// Assumes: take_fid is the frame this module offered, and give is asserted only for used frames.
module tju_free_pool #(
    parameter int NFRAMES = 16,
    parameter int FID_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [FID_W-1:0]   take_fid,
    input  logic               give,
    input  logic [FID_W-1:0]   give_fid,
    output logic [NFRAMES-1:0] used,
    output logic               empty,
    output logic [FID_W-1:0]   pick
);
    // Keep ownership: set on grant, clear on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else begin
            if (take) used[take_fid] <= 1'b1;
            if (give) used[give_fid] <= 1'b0;
        end
    end

    assign empty = &used;

    // Priority encoder: lowest free index wins
    always_comb begin
        pick = '0;
        for (int i = NFRAMES - 1; i >= 0; i--) begin
            if (!used[i]) pick = FID_W'(i);
        end
    end
endmodule

// File: rtl/tju_frame_table.sv
// Per-frame join counter and code pointer.
// Assumes: load and dec never target the same frame in one cycle. Clear has the highest priority.
module tju_frame_table #(
    parameter int NFRAMES = 16,
    parameter int FID_W   = 4,
    parameter int CNT_W   = 4,
    parameter int CODE_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [FID_W-1:0]            load_fid,
    input  logic [CNT_W-1:0]            load_cnt,
    input  logic [CODE_W-1:0]           load_code,
    input  logic                        dec,
    input  logic [FID_W-1:0]            dec_fid,
    input  logic                        clr,
    input  logic [FID_W-1:0]            clr_fid,
    output logic [NFRAMES*CNT_W-1:0]    cnt_flat,
    output logic [NFRAMES*CODE_W-1:0]   code_flat
);
    for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
        logic [CNT_W-1:0]  cnt_q;
        logic [CODE_W-1:0] code_q;

        // Count register: clear on free, load on allocate, step down on accepted write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clr && clr_fid == FID_W'(f)) begin
                cnt_q <= '0;
            end else if (load && load_fid == FID_W'(f)) begin
                cnt_q <= load_cnt;
            end else if (dec && dec_fid == FID_W'(f)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end

        // Code pointer captured at allocation
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (load && load_fid == FID_W'(f)) begin
                code_q <= load_code;
            end
        end

        assign cnt_flat[f*CNT_W +: CNT_W]    = cnt_q;
        assign code_flat[f*CODE_W +: CODE_W] = code_q;
    end
endmodule

// File: rtl/tju_slot_mem.sv
// Frame slot storage: one write port, one combinational read port for the pre-load stage.
// Assumes: contents are undefined until written. Nothing reads a slot before it is written.
module tju_slot_mem #(
    parameter int NFRAMES = 16,
    parameter int NSLOTS  = 8,
    parameter int FID_W   = 4,
    parameter int SLOT_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [FID_W-1:0]  wr_fid,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FID_W-1:0]  rd_fid,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = NFRAMES * NSLOTS;

    logic [DATA_W-1:0] mem_q [WORDS];

    // Commit accepted slot writes
    always_ff @(posedge clk) begin
        if (wr) mem_q[int'(wr_fid) * NSLOTS + int'(wr_slot)] <= wr_data;
    end

    assign rd_data = mem_q[int'(rd_fid) * NSLOTS + int'(rd_slot)];
endmodule

// File: rtl/tju_ready_fifo.sv
// Ready-thread queue with a first-word fall-through head.
// Assumes: push is never asserted while full (the caller rejects it).
module tju_ready_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     buf_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] n_q;
    logic             do_pop;

    assign do_pop = pop && valid;
    assign full   = (n_q == CNT_W'(DEPTH));
    assign valid  = (n_q != '0);
    assign head   = buf_q[rd_q];

    // Store the entry being pushed
    always_ff @(posedge clk) begin
        if (push) buf_q[wr_q] <= push_data;
    end

    // Advance the pointers and the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            n_q  <= '0;
        end else begin
            if (push)   wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
            if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
            n_q <= n_q + CNT_W'(push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/thread_join_unit.sv
// Thread join unit: frame allocation, join counting, ready queue, frame release.
// Assumes: one write, one allocate and one free per cycle. All decisions use the state
// at the start of the cycle. A free overrides a same-cycle write to the same frame.
module thread_join_unit #(
    parameter int NFRAMES  = 16,
    parameter int NSLOTS   = 8,
    parameter int DATA_W   = 32,
    parameter int CODE_W   = 16,
    parameter int MAX_JOIN = 15,
    localparam int FID_W   = $clog2(NFRAMES),
    localparam int SLOT_W  = $clog2(NSLOTS),
    localparam int CNT_W   = $clog2(MAX_JOIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [CODE_W-1:0] alloc_code,
    input  logic [CNT_W-1:0]  alloc_count,
    output logic              alloc_grant,
    output logic              alloc_busy,
    output logic [FID_W-1:0]  alloc_fid,
    input  logic              st_valid,
    input  logic [FID_W-1:0]  st_fid,
    input  logic [SLOT_W-1:0] st_slot,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_err,
    input  logic              free_valid,
    input  logic [FID_W-1:0]  free_fid,
    output logic              rdy_valid,
    output logic [FID_W-1:0]  rdy_fid,
    output logic [CODE_W-1:0] rdy_code,
    input  logic              rdy_pop,
    input  logic [FID_W-1:0]  pl_fid,
    input  logic [SLOT_W-1:0] pl_slot,
    output logic [DATA_W-1:0] pl_data
);
    import tju_pkg::*;

    localparam int ENT_W = FID_W + CODE_W;

    logic [NFRAMES-1:0]        used;
    logic                      pool_empty;
    logic [FID_W-1:0]          pool_pick;
    logic [NFRAMES*CNT_W-1:0]  cnt_flat;
    logic [NFRAMES*CODE_W-1:0] code_flat;
    logic [CNT_W-1:0]          tgt_cnt;
    logic [CODE_W-1:0]         tgt_code;
    logic                      tgt_used;
    logic                      free_ok;
    logic                      q_full;
    logic                      accept;
    logic [ENT_W-1:0]          q_head;
    st_verdict_e               verdict;

    assign tgt_used    = used[st_fid];
    assign tgt_cnt     = cnt_flat[st_fid*CNT_W +: CNT_W];
    assign tgt_code    = code_flat[st_fid*CODE_W +: CODE_W];
    assign free_ok     = free_valid && used[free_fid];
    assign alloc_busy  = pool_empty;
    assign alloc_fid   = pool_pick;
    assign alloc_grant = alloc_req && !pool_empty && (alloc_count != '0);
    assign accept      = (verdict == SV_OK) || (verdict == SV_LAST);

    // Classify the incoming slot write against start-of-cycle state
    always_comb begin
        verdict = SV_NONE;
        if (st_valid) begin
            if (!tgt_used || tgt_cnt == '0)                 verdict = SV_BAD;
            else if (free_valid && free_fid == st_fid)      verdict = SV_DROP;
            else if (tgt_cnt == CNT_W'(1) && q_full)        verdict = SV_BAD;
            else if (tgt_cnt == CNT_W'(1))                  verdict = SV_LAST;
            else                                            verdict = SV_OK;
        end
    end

    // One-cycle error pulse for rejected writes
    always_ff @(posedge clk) begin
        if (!rst_n) st_err <= 1'b0;
        else        st_err <= (verdict == SV_BAD);
    end

    tju_free_pool #(.NFRAMES(NFRAMES), .FID_W(FID_W)) pool_i (
        .clk(clk), .rst_n(rst_n),
        .take(alloc_grant), .take_fid(pool_pick),
        .give(free_ok), .give_fid(free_fid),
        .used(used), .empty(pool_empty), .pick(pool_pick)
    );

    tju_frame_table #(.NFRAMES(NFRAMES), .FID_W(FID_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .load(alloc_grant), .load_fid(pool_pick), .load_cnt(alloc_count), .load_code(alloc_code),
        .dec(accept), .dec_fid(st_fid),
        .clr(free_ok), .clr_fid(free_fid),
        .cnt_flat(cnt_flat), .code_flat(code_flat)
    );

    tju_slot_mem #(.NFRAMES(NFRAMES), .NSLOTS(NSLOTS), .FID_W(FID_W), .SLOT_W(SLOT_W),
                   .DATA_W(DATA_W)) mem_i (
        .clk(clk),
        .wr(accept), .wr_fid(st_fid), .wr_slot(st_slot), .wr_data(st_data),
        .rd_fid(pl_fid), .rd_slot(pl_slot), .rd_data(pl_data)
    );

    tju_ready_fifo #(.DEPTH(NFRAMES), .W(ENT_W)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(verdict == SV_LAST), .push_data({st_fid, tgt_code}),
        .pop(rdy_pop), .full(q_full), .valid(rdy_valid), .head(q_head)
    );

    assign rdy_fid  = q_head[ENT_W-1 -: FID_W];
    assign rdy_code = q_head[CODE_W-1:0];
endmodule

// File: rtl/tju_checker.sv
// Temporal checks for the thread join unit, attached by bind.
module tju_checker #(
    parameter int NFRAMES = 16,
    parameter int FID_W   = 4,
    parameter int CNT_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_req,
    input logic [CNT_W-1:0]     alloc_count,
    input logic                 alloc_grant,
    input logic                 alloc_busy,
    input logic [FID_W-1:0]     alloc_fid,
    input logic                 st_valid,
    input logic [FID_W-1:0]     st_fid,
    input logic                 st_err,
    input logic                 rdy_valid,
    input logic                 free_valid,
    input logic [FID_W-1:0]     free_fid,
    input logic [NFRAMES-1:0]   used,
    input tju_pkg::st_verdict_e verdict
);
    import tju_pkg::*;

    assert_grant_picks_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> !used[alloc_fid]);
    assert_grant_marks_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> used[$past(alloc_fid)]);
    assert_busy_blocks_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_busy |-> !alloc_grant);
    assert_zero_count_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_count == '0) |-> !alloc_grant);
    assert_last_makes_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == SV_LAST) |=> rdy_valid);
    assert_bad_store_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !used[st_fid]) |=> st_err);
    assert_free_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid && used[free_fid]) |=> !used[$past(free_fid)]);
    assert_drop_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == SV_DROP) |=> !st_err);
endmodule

bind thread_join_unit tju_checker #(.NFRAMES(NFRAMES), .FID_W(FID_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_count(alloc_count), .alloc_grant(alloc_grant),
    .alloc_busy(alloc_busy), .alloc_fid(alloc_fid),
    .st_valid(st_valid), .st_fid(st_fid), .st_err(st_err), .rdy_valid(rdy_valid),
    .free_valid(free_valid), .free_fid(free_fid), .used(used), .verdict(verdict)
);

// File: tb/thread_join_unit_tb.sv
`timescale 1ns/1ps
module thread_join_unit_tb_top;
    localparam int NF = 16;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_req;
    logic [15:0] alloc_code;
    logic [3:0]  alloc_count;
    logic        alloc_grant, alloc_busy;
    logic [3:0]  alloc_fid;
    logic        st_valid;
    logic [3:0]  st_fid;
    logic [2:0]  st_slot;
    logic [31:0] st_data;
    logic        st_err;
    logic        free_valid;
    logic [3:0]  free_fid;
    logic        rdy_valid;
    logic [3:0]  rdy_fid;
    logic [15:0] rdy_code;
    logic        rdy_pop;
    logic [3:0]  pl_fid;
    logic [2:0]  pl_slot;
    logic [31:0] pl_data;

    always #2 clk = ~clk;  // 250 MHz

    thread_join_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_code(alloc_code), .alloc_count(alloc_count),
        .alloc_grant(alloc_grant), .alloc_busy(alloc_busy), .alloc_fid(alloc_fid),
        .st_valid(st_valid), .st_fid(st_fid), .st_slot(st_slot), .st_data(st_data),
        .st_err(st_err), .free_valid(free_valid), .free_fid(free_fid),
        .rdy_valid(rdy_valid), .rdy_fid(rdy_fid), .rdy_code(rdy_code), .rdy_pop(rdy_pop),
        .pl_fid(pl_fid), .pl_slot(pl_slot), .pl_data(pl_data)
    );

    int checks = 0;
    int errors = 0;

    // Reference state derived from the requirements
    bit m_used [NF];
    int m_cnt  [NF];
    int m_code [NF];
    int m_data [NF*NS];
    bit m_wr   [NF*NS];
    int q_f [NF];
    int q_c [NF];
    int qn;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_req = 0; alloc_code = '0; alloc_count = '0;
        st_valid = 0; st_fid = '0; st_slot = '0; st_data = '0;
        free_valid = 0; free_fid = '0; rdy_pop = 0; pl_fid = '0; pl_slot = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        for (int i = 0; i < NF; i++) begin m_used[i] = 0; m_cnt[i] = 0; m_code[i] = 0; end
        for (int i = 0; i < NF*NS; i++) m_wr[i] = 0;
        qn = 0;
        #1;
        chk("R1 busy", alloc_busy, 0);
        chk("R1 rdy_valid", rdy_valid, 0);
        chk("R1 st_err", st_err, 0);
        chk("R1 alloc_fid", alloc_fid, 0);
    endtask

    // One cycle: drive, check same-cycle outputs, advance model at edge, check registered outputs
    task automatic step(input bit ar, input int ac, input int an,
                        input bit sv, input int sf, input int ss, input int sd,
                        input bit fv, input int ff, input bit pp);
        bit busy, eg, fo, was_full;
        int pick, v;
        string tg, te;
        alloc_req = ar; alloc_code = 16'(ac); alloc_count = 4'(an);
        st_valid = sv; st_fid = 4'(sf); st_slot = 3'(ss); st_data = 32'(sd);
        free_valid = fv; free_fid = 4'(ff); rdy_pop = pp;
        #1;
        busy = 1; pick = 0;
        for (int i = NF - 1; i >= 0; i--) if (!m_used[i]) begin busy = 0; pick = i; end
        eg = ar && an != 0 && !busy;
        tg = (an == 0) ? "R4" : (busy ? "R3" : (fv ? "R9" : "R2"));
        chk(tg, alloc_grant, eg);
        chk("R3 busy", alloc_busy, busy);
        if (eg) chk(tg, alloc_fid, pick);
        // Verdict: 0 none, 1 accepted, 2 last, 3 rejected, 4 dropped
        was_full = (qn == NF);
        v = 0; te = "R7";
        if (sv) begin
            if (!m_used[sf] || m_cnt[sf] == 0) v = 3;
            else if (fv && ff == sf)           begin v = 4; te = "R10"; end
            else if (m_cnt[sf] == 1 && was_full) begin v = 3; te = "R11"; end
            else if (m_cnt[sf] == 1)           v = 2;
            else                               v = 1;
        end
        fo = fv && m_used[ff];
        @(posedge clk); #1;
        if (pp && qn > 0) begin
            for (int i = 0; i < NF - 1; i++) begin q_f[i] = q_f[i+1]; q_c[i] = q_c[i+1]; end
            qn--;
        end
        if (v == 2) begin q_f[qn] = sf; q_c[qn] = m_code[sf]; qn++; end
        if (v == 1 || v == 2) begin
            m_cnt[sf]--;
            m_data[sf*NS+ss] = sd; m_wr[sf*NS+ss] = 1;
        end
        if (fo) begin m_used[ff] = 0; m_cnt[ff] = 0; end
        if (eg) begin m_used[pick] = 1; m_cnt[pick] = an; m_code[pick] = ac; end
        chk(te, st_err, v == 3);
        chk("R5 rdy_valid", rdy_valid, qn > 0);
        if (qn > 0) begin
            chk("R6 head fid", rdy_fid, q_f[0]);
            chk("R6 head code", rdy_code, q_c[0]);
        end
        idle_inputs();
        pl_fid = 4'(sf); pl_slot = 3'(ss);
        #1;
        if (m_wr[sf*NS+ss]) chk("R12 pl_data", pl_data, m_data[sf*NS+ss]);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        do_reset();

        // R2/R4: fill all frames, counts 1..4, with a zero-count request in the middle
        for (int f = 0; f < NF; f++) begin
            if (f == 7) step(1, 16'h7777, 0, 0, 0, 0, 0, 0, 0, 0);  // R4 refused
            step(1, 16'h100 + f, (f % 4) + 1, 0, 0, 0, 0, 0, 0, 0);
        end
        step(1, 16'h999, 2, 0, 0, 0, 0, 0, 0, 0);  // R3 all frames taken

        // R5/R7/R12: four write rounds; frames with lower counts see rejected extra writes
        for (int r = 0; r < 4; r++)
            for (int f = 0; f < NF; f++)
                step(0, 0, 0, 1, f, r, 32'hA000 + f*16 + r, 0, 0, 0);

        // R6: drain the queue in completion order
        for (int k = 0; k < NF + 1; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R8: free frames, then reuse and write to a freed frame
        step(0, 0, 0, 0, 0, 0, 0, 1, 5, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 7, 0);
        step(0, 0, 0, 1, 7, 0, 1, 0, 0, 0);            // R8 write to freed frame errors
        step(1, 16'h222, 2, 0, 0, 0, 0, 1, 9, 0);      // R9 alloc picks 5 while 9 is freed
        step(0, 0, 0, 0, 0, 0, 0, 1, 9, 0);            // R8 free of unallocated frame
        step(1, 16'h333, 1, 0, 0, 0, 0, 0, 0, 0);      // R8 next pick is 7
        step(0, 0, 0, 1, 5, 1, 16'h55, 1, 5, 0);       // R10 write dropped by free
        step(0, 0, 0, 1, 5, 1, 16'h66, 0, 0, 0);       // R10 follow-up write errors
        step(0, 0, 0, 1, 7, 2, 16'h77, 0, 0, 0);       // R5 completes frame 7
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R11: fill the queue, then a completing write must be refused
        do_reset();
        for (int f = 0; f < NF; f++) step(1, 16'h400 + f, 1, 0, 0, 0, 0, 0, 0, 0);
        for (int f = 0; f < NF; f++) step(0, 0, 0, 1, f, 0, f, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 3, 0);
        step(1, 16'h4AA, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3, 4, 16'hBAD, 0, 0, 0);      // R11 refused while full
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 3, 4, 16'h600D, 0, 0, 0);     // R11 retry accepted

        // Mixed pseudo-random traffic covering all requirements
        seed = 32'h1234_5678;
        for (int k = 0; k < 600; k++) begin
            int a, b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            a = seed & 32'h7FFF_FFFF;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            b = seed & 32'h7FFF_FFFF;
            step((a % 3) == 0, b % 65536, (a >> 4) % 5,
                 (a >> 8) % 2 == 1, (a >> 9) % NF, (a >> 13) % NS, b,
                 (b >> 16) % 4 == 0, (b >> 18) % NF, (a >> 20) % 2 == 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule